// File: doc/BRIEF.md
# Second-Order Bitstream Decimation Filter

This block turns the one-bit output of a first-order delta-sigma modulator into signed 16-bit words. It uses a second-order cascaded integrator-comb structure that reduces the rate by 1024. Two integrators run at the modulator rate whenever a sample is strobed in. Once every 1024 accepted samples, the second integrator is handed to two comb stages. These combs run at the decimated rate and finish with a rounding step.

Each stage is only as wide as its contribution to the result requires. Both integrators carry 21 bits. The first comb keeps 18 bits and the second keeps 17, and each drops low-order bits on entry. All arithmetic wraps modulo the stage width, so no saturation logic is needed. The 17th bit exists only so that the final 16-bit word can be rounded. A one-cycle strobe marks each new word, and the word holds its value until the next strobe.

Top module: `cic2_bitstream_decim`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high for exactly one cycle. It rises in the second cycle after the cycle that presents the 1024th, 2048th, ... accepted sample since reset, and at no other time.
- R3: A cycle with `in_valid` low has no effect. The value of `in_bit` in that cycle is ignored, and the sample count does not advance.
- R4: An accepted bit 1 enters the first integrator as +1, and a bit 0 enters as -1. A steady stream of zeros settles to `out_data` = 16'h8000 (-32768).
- R5: A stream that alternates 1,0,1,0 settles to `out_data` = 0.
- R6: The DC gain is 1024^2 = 2^20 at the 21-bit level, so one output LSB equals 32 integrator LSBs. A repeating 1,1,1,0 stream settles to 16384.
- R7: Pruning works as follows. The first comb takes bits [20:3] of the second integrator. The second comb takes bits [17:1] of the first comb's result. Each comb subtracts its own input from one decimated sample earlier, modulo its width.
- R8: The output word is bits [16:1] of (second comb result + 1) modulo 2^17. This adds half an output LSB before dropping the guard bit.
- R9: Every stage wraps with no saturation. A steady stream of ones aliases onto the same code as zeros (16'h8000), and integrator wrap over long runs does not disturb the output.
- R10: `out_data` changes only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_bit` as a sample to accept |
| in_bit | input | 1 | Modulator bit |
| out_data | output | 16 | Rounded decimated word, two's complement |
| out_valid | output | 1 | One-cycle strobe for a new `out_data` |

## Verification
The rounding step only shows at the port when the second comb produces an odd value. Steady or periodic streams whose period divides 1024 never produce one, because their truncations are exact. To reach that case, the bench drives long pseudo-random bitstreams over several decimation periods, and it counts how many outputs needed rounding. The bench's bit-accurate model takes the truncation positions straight from the requirements. Randomly placed idle cycles carrying garbage bits make sure that the count and the integrators ignore unstrobed cycles, while the output timing is measured from the 1024th accepted sample.

// File: rtl/cic2_bitstream_decim.sv
module cic2_bitstream_decim #(
  parameter int RATIO_LOG2 = 10,
  parameter int IW         = 21,
  parameter int C1W        = 18,
  parameter int C2W        = 17,
  parameter int OW         = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic [OW-1:0] out_data,
  output logic          out_valid
);
  localparam int D1 = IW - C1W;
  localparam int D2 = C1W - C2W;

  logic [IW-1:0]         acc1, acc2;
  logic [RATIO_LOG2-1:0] cnt;
  logic                  dump;
  logic [C1W-1:0]        dly1;
  logic [C2W-1:0]        dly2;

  wire [IW-1:0]  step    = {{(IW-1){~in_bit}}, 1'b1};
  wire [C1W-1:0] comb1_i = acc2[IW-1:D1];
  wire [C1W-1:0] comb1_o = comb1_i - dly1;
  wire [C2W-1:0] comb2_i = comb1_o[C1W-1:D2];
  wire [C2W-1:0] comb2_o = comb2_i - dly2;
  wire [C2W-1:0] rounded = comb2_o + {{(C2W-1){1'b0}}, 1'b1};

  logic unused_bits;
  assign unused_bits = ^{acc2[D1-1:0], comb1_o[D2-1:0], rounded[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1      <= '0;
      acc2      <= '0;
      cnt       <= '0;
      dump      <= 1'b0;
      dly1      <= '0;
      dly2      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (in_valid) begin
        acc1 <= acc1 + step;
        acc2 <= acc2 + acc1;
        cnt  <= cnt + 1'b1;
      end
      dump      <= in_valid && (cnt == '1);
      out_valid <= dump;
      if (dump) begin
        dly1     <= comb1_i;
        dly2     <= comb2_i;
        out_data <= rounded[C2W-1:1];
      end
    end
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2

  AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cnt <= RATIO_LOG2'(2)); // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc1) && $stable(acc2) && $stable(cnt)); // R3

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((acc1 - $past(acc1)) == IW'(1)) || (($past(acc1) - acc1) == IW'(1))); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R10
endmodule

// File: tb/tb_cic2_bitstream_decim.sv
module tb_cic2_bitstream_decim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic [15:0] out_data;
  logic        out_valid;

  cic2_bitstream_decim dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [20:0] m1, m2;
  logic [17:0] md1;
  logic [16:0] md2;
  int          mcount;
  int          odd_seen;
  int          due_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] last_out;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (due_q.size() != 0 && cyc == due_q[0]) begin
        chk("R2 strobe at 2nd cycle after block end", {31'd0, out_valid}, 32'd1);
        chk("R7/R8 output word vs pruned model", {16'd0, out_data}, {16'd0, exp_q[0]});
        last_out = out_data;
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
      end else if (out_valid) begin
        chk("R2 unexpected strobe", 32'd1, 32'd0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 out_data in reset", {16'd0, out_data}, 32'd0);
    m1 = '0; m2 = '0; md1 = '0; md2 = '0; mcount = 0;
    due_q.delete(); exp_q.delete();
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 out_data after reset", {16'd0, out_data}, 32'd0);
  endtask

  task automatic push_bit(input logic b);
    logic [17:0] c1;
    logic [16:0] c2, r;
    in_valid = 1'b1;
    in_bit = b;
    m2 = m2 + m1;
    m1 = m1 + (b ? 21'd1 : 21'h1FFFFF);
    mcount++;
    if (mcount == 1024) begin
      mcount = 0;
      c1 = m2[20:3] - md1;
      md1 = m2[20:3];
      c2 = c1[17:1] - md2;
      md2 = c1[17:1];
      r = c2 + 17'd1;
      if (c2[0]) odd_seen++;
      due_q.push_back(cyc + 2);
      exp_q.push_back(r[16:1]);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (due_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_zeros();
    do_reset();
    for (int i = 0; i < 4 * 1024; i++) push_bit(1'b0);
    drain();
    chk("R4 zeros settle to -32768", {16'd0, last_out}, 32'h8000);
  endtask

  task automatic t_ones();
    do_reset();
    for (int i = 0; i < 4 * 1024; i++) push_bit(1'b1);
    drain();
    chk("R9 ones alias to 16'h8000", {16'd0, last_out}, 32'h8000);
  endtask

  task automatic t_alternate();
    do_reset();
    for (int i = 0; i < 4 * 1024; i++) push_bit(i % 2 == 0);
    drain();
    chk("R5 alternating settles to 0", {16'd0, last_out}, 32'd0);
  endtask

  task automatic t_three_quarters();
    do_reset();
    for (int i = 0; i < 4 * 1024; i++) push_bit(i % 4 != 3);
    drain();
    chk("R6 gain: 1110 stream gives 16384", {16'd0, last_out}, 32'd16384);
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 4 * 1024; i++) begin
      int idle;
      idle = $urandom_range(0, 3);
      for (int k = 0; k < idle; k++) begin
        in_bit = $urandom_range(0, 1);
        @(negedge clk);
      end
      push_bit(i % 4 != 3);
    end
    drain();
    chk("R3 idle cycles ignored, 1110 still 16384", {16'd0, last_out}, 32'd16384);
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    do_reset();
    odd_seen = 0;
    lfsr = 16'hACE1;
    for (int i = 0; i < 8 * 1024; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push_bit(lfsr[0]);
    end
    drain();
    chk("R8 rounding case reached", {31'd0, odd_seen > 0}, 32'd1);
  endtask

  task automatic t_long_wrap();
    do_reset();
    for (int i = 0; i < 12 * 1024; i++) push_bit(i % 8 < 5);
    drain();
    chk("R9 5/8 stream after integrator wrap gives 8192", {16'd0, last_out}, 32'd8192);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_zeros();
    t_ones();
    t_alternate();
    t_three_quarters();
    t_gaps();
    t_random();
    t_long_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule